// File: doc/BRIEF.md
# Command-Driven I2C Bus Master

This block drives an I2C bus one step at a time under software control. Software writes a 4-bit command, and the engine runs one bus primitive or a short fused chain of primitives. The primitives are START, byte transmit, byte receive, acknowledge sample, acknowledge drive and STOP. When the last step of a command ends, the engine raises a sticky completion flag. Software can wait on this flag before it issues the next command, so a full transfer is built from a list of commands rather than from one autonomous transaction.

SCL and SDA are open-drain. Each line has an output enable, and an enable of 1 pulls the line low. The SDA line level comes back on its own input. Bit timing comes from a 6-bit prescaler P. The bus runs at fclk / (4P + 8), in four equal quarters of P + 2 clock cycles per SCL period. Transmit data enters through a valid/ready port. `tx_ready` is high only while no command is executing, and a word offered while it is low is not taken and must be held by the source. In auto-send mode, every accepted transmit word also launches a byte transmit followed by an acknowledge sample.

Top module: `i2c_cmd_master`

## Requirements
- R1: After reset, both line enables are 0 (lines released), `busy`, `done` and `engine_active` are 0, and `tx_ready` is 1.
- R2: Command 1 (START) pulls SDA low while SCL is high, leaves SCL held low, and sets `busy`.
- R3: Command 2 produces exactly 8 SCL high pulses that carry the transmit word MSB first, with SDA changing only while SCL is low.
- R4: Command 3 produces one SCL pulse and stores the SDA level sampled during it in `ack_in` (0 = acknowledged).
- R5: Command 4 releases SDA, produces 8 SCL pulses, and loads the 8 sampled bits MSB first into `rx_data`.
- R6: Command 5 produces one SCL pulse with SDA low when `ack_out` is 0 and released when it is 1; `ack_we` writes `ack_wval` into `ack_out`.
- R7: Command 6 (STOP) releases SDA while SCL is high, leaves both lines released, and clears `busy`.
- R8: `done` sets when the last step of a command completes and stays set until a `done_clr` pulse clears it.
- R9: While the engine runs, consecutive SCL rising edges within a byte are 4P + 8 clock cycles apart.
- R10: Compound codes run as chains: 9 = START, transmit, acknowledge sample; 0xA = transmit, acknowledge sample; 0xB = receive, then drive ACK after setting `ack_out` to 0; 0xC = receive, then drive NACK after setting `ack_out` to 1.
- R11: A transmit word is accepted only while `tx_ready` is high. With `auto_send` high, an accepted word starts the 0xA chain.
- R12: A command written while the engine is running is ignored. Codes 0, 7, 8 and 0xD to 0xF start nothing and leave `done` clear.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| prescale | input | 6 | Bit-rate prescaler P |
| auto_send | input | 1 | Launch transmit + ACK sample on each accepted word |
| cmd_we | input | 1 | Command write strobe |
| cmd_code | input | 4 | Command code |
| tx_valid | input | 1 | Transmit word offered |
| tx_ready | output | 1 | Transmit word can be accepted (engine idle) |
| tx_data | input | 8 | Transmit word |
| ack_we | input | 1 | Write strobe for the ACK-to-send bit |
| ack_wval | input | 1 | Value for the ACK-to-send bit |
| done_clr | input | 1 | Clears the completion flag |
| rx_data | output | 8 | Last received byte |
| busy | output | 1 | Bus owned (START seen, STOP not yet) |
| done | output | 1 | Sticky command-complete flag |
| ack_in | output | 1 | Last sampled acknowledge bit |
| ack_out | output | 1 | Acknowledge bit to send |
| engine_active | output | 1 | A command is executing |
| scl_oe | output | 1 | Pull SCL low |
| sda_oe | output | 1 | Pull SDA low |
| sda_in | input | 1 | SDA line level |

## Verification
A wrong step index or a lost pending flag shows up as a missing or extra SCL pulse within one quarter period, and it often leaves `done` never set, so the command wait runs out. A bad shift register shows up as wrong bits on SDA at the next SCL rise, or as a wrong `rx_data` once the receive ends. A faulty quarter counter changes the measured spacing between SCL rises straight away. Misordered line enables appear as a START or STOP seen by a passive bus monitor where a data bit should be.

// File: rtl/i2c_cmd_pkg.sv
package i2c_cmd_pkg;

  typedef enum logic [2:0] {
    OP_NONE  = 3'd0,
    OP_START = 3'd1,
    OP_SEND  = 3'd2,
    OP_RACK  = 3'd3,
    OP_RECV  = 3'd4,
    OP_TACK  = 3'd5,
    OP_STOP  = 3'd6
  } op_e;

  // Up to three steps per command, plus an optional ack-bit preset
  typedef struct packed {
    op_e  s0;
    op_e  s1;
    op_e  s2;
    logic force_ack;
    logic ack_val;
  } plan_t;

  localparam logic [3:0] CMD_SEND_RACK = 4'hA;

  function automatic plan_t decode_cmd(input logic [3:0] code);
    plan_t p;
    p = '0;
    case (code)
      4'h1: p.s0 = OP_START;
      4'h2: p.s0 = OP_SEND;
      4'h3: p.s0 = OP_RACK;
      4'h4: p.s0 = OP_RECV;
      4'h5: p.s0 = OP_TACK;
      4'h6: p.s0 = OP_STOP;
      4'h9: begin p.s0 = OP_START; p.s1 = OP_SEND; p.s2 = OP_RACK; end
      4'hA: begin p.s0 = OP_SEND;  p.s1 = OP_RACK; end
      4'hB: begin p.s0 = OP_RECV;  p.s1 = OP_TACK; p.force_ack = 1'b1; p.ack_val = 1'b0; end
      4'hC: begin p.s0 = OP_RECV;  p.s1 = OP_TACK; p.force_ack = 1'b1; p.ack_val = 1'b1; end
      default: ;
    endcase
    return p;
  endfunction

endpackage

// File: rtl/i2c_qtick.sv
module i2c_qtick #(
  parameter int PRE_W = 6
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run,
  input  logic [PRE_W-1:0] prescale,
  output logic             tick
);
  localparam int CNT_W = PRE_W + 1;

  logic [CNT_W-1:0] cnt;
  logic [CNT_W-1:0] limit;

  assign limit = {1'b0, prescale} + CNT_W'(1);
  assign tick  = run && (cnt == limit);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)            cnt <= '0;
    else if (!run || tick) cnt <= '0;
    else                   cnt <= cnt + CNT_W'(1);
  end

  // R9
  tick_gap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    tick |=> !tick);

endmodule

// File: rtl/i2c_bit_engine.sv
module i2c_bit_engine import i2c_cmd_pkg::*; #(
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          go,
  input  op_e           go_op,
  input  logic [DW-1:0] tx_byte,
  input  logic          ack_bit,
  input  logic          sda_in,
  input  logic          tick,
  output logic          active,
  output logic          op_done,
  output logic [DW-1:0] rx_sh,
  output logic          scl_oe,
  output logic          sda_oe
);
  localparam int BC_W = $clog2(DW);

  op_e            kind;
  logic [1:0]     q;
  logic [BC_W-1:0] bitc;
  logic [DW-1:0]  tx_sh;
  logic           last_bit, scl_w, sda_w, is_data;

  assign is_data  = (kind == OP_SEND) || (kind == OP_RECV);
  assign last_bit = is_data ? (bitc == BC_W'(DW - 1)) : 1'b1;

  // Line enables per quarter; SCL high during quarters 2 and 3 of a bit
  always_comb begin
    scl_w = scl_oe;
    sda_w = sda_oe;
    case (kind)
      OP_START: begin scl_w = (q == 2'd0) || (q == 2'd3); sda_w = q[1];  end
      OP_STOP:  begin scl_w = (q == 2'd0);                sda_w = !q[1]; end
      OP_SEND, OP_TACK: begin
        scl_w = !q[1];
        sda_w = (q == 2'd0) ? sda_oe : !tx_sh[DW-1];
      end
      OP_RECV, OP_RACK: begin scl_w = !q[1]; sda_w = 1'b0; end
      default: ;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      active  <= 1'b0;
      op_done <= 1'b0;
      kind    <= OP_NONE;
      q       <= '0;
      bitc    <= '0;
      tx_sh   <= '0;
      rx_sh   <= '0;
      scl_oe  <= 1'b0;
      sda_oe  <= 1'b0;
    end else begin
      op_done <= 1'b0;
      if (go) begin
        active <= 1'b1;
        kind   <= go_op;
        q      <= '0;
        bitc   <= '0;
        tx_sh  <= (go_op == OP_TACK) ? {ack_bit, {(DW-1){1'b0}}} : tx_byte;
      end else if (active) begin
        scl_oe <= scl_w;
        sda_oe <= sda_w;
        if (tick) begin
          if (q == 2'd2 && (kind == OP_RECV || kind == OP_RACK))
            rx_sh <= {rx_sh[DW-2:0], sda_in};
          if (q == 2'd3) begin
            q <= '0;
            if (last_bit) begin
              active  <= 1'b0;
              op_done <= 1'b1;
              if (kind != OP_STOP) scl_oe <= 1'b1;
            end else begin
              bitc  <= bitc + 1'b1;
              tx_sh <= {tx_sh[DW-2:0], 1'b0};
            end
          end else begin
            q <= q + 2'd1;
          end
        end
      end
    end
  end

  // R3
  data_scl_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!$stable(sda_oe) && (kind == OP_SEND || kind == OP_TACK ||
                          kind == OP_RECV || kind == OP_RACK))
    |-> (scl_oe && $past(scl_oe)));

  // R2 R7
  cond_only_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!$stable(sda_oe) && !scl_oe && !$past(scl_oe))
    |-> (kind == OP_START || kind == OP_STOP));

  // R12
  go_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    go |-> !active);

endmodule

// File: rtl/i2c_cmd_seq.sv
module i2c_cmd_seq import i2c_cmd_pkg::*; #(
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          cmd_we,
  input  logic [3:0]    cmd_code,
  input  logic          tx_fire,
  input  logic          auto_send,
  input  logic          ack_we,
  input  logic          ack_wval,
  input  logic          done_clr,
  input  logic          op_done,
  input  logic [DW-1:0] eng_rx,
  output logic          go,
  output op_e           go_op,
  output logic          running,
  output logic          busy,
  output logic          done,
  output logic          ack_in,
  output logic          ack_out,
  output logic [DW-1:0] rx_data
);
  plan_t      cmd_plan, launch_plan, run_plan;
  logic [1:0] idx;
  logic       pend, cmd_ok, launch, finish;
  op_e        cur_op, nxt_op;

  assign cmd_plan    = decode_cmd(cmd_code);
  assign cmd_ok      = cmd_we && (cmd_plan.s0 != OP_NONE);
  assign launch_plan = cmd_ok ? cmd_plan : decode_cmd(CMD_SEND_RACK);
  assign launch      = !running && (cmd_ok || (tx_fire && auto_send));

  always_comb begin
    case (idx)
      2'd0:    begin cur_op = run_plan.s0; nxt_op = run_plan.s1; end
      2'd1:    begin cur_op = run_plan.s1; nxt_op = run_plan.s2; end
      default: begin cur_op = run_plan.s2; nxt_op = OP_NONE;     end
    endcase
  end

  assign go     = running && pend;
  assign go_op  = cur_op;
  assign finish = op_done && (nxt_op == OP_NONE);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      run_plan <= '0;
      idx      <= '0;
      pend     <= 1'b0;
      running  <= 1'b0;
      busy     <= 1'b0;
      done     <= 1'b0;
      ack_in   <= 1'b0;
      ack_out  <= 1'b0;
      rx_data  <= '0;
    end else begin
      if (ack_we) ack_out <= ack_wval;
      if (launch) begin
        run_plan <= launch_plan;
        idx      <= '0;
        pend     <= 1'b1;
        running  <= 1'b1;
        if (launch_plan.force_ack) ack_out <= launch_plan.ack_val;
      end
      if (go) pend <= 1'b0;
      if (done_clr) done <= 1'b0;
      if (op_done) begin
        case (cur_op)
          OP_START: busy    <= 1'b1;
          OP_STOP:  busy    <= 1'b0;
          OP_RECV:  rx_data <= eng_rx;
          OP_RACK:  ack_in  <= eng_rx[0];
          default: ;
        endcase
        if (finish) begin
          running <= 1'b0;
          done    <= 1'b1;
        end else begin
          idx  <= idx + 2'd1;
          pend <= 1'b1;
        end
      end
    end
  end

  // R12
  ignore_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (running && cmd_we && !op_done) |=> (running && idx == $past(idx)));

  // R8
  done_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(done) |-> ($past(running) && !running));

  // R7
  busy_fall_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) |-> ($past(op_done) && $past(cur_op) == OP_STOP));

  // R2
  busy_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> ($past(cur_op) == OP_START));

endmodule

// File: rtl/i2c_cmd_master.sv
module i2c_cmd_master import i2c_cmd_pkg::*; #(
  parameter int PRE_W = 6,
  parameter int DW    = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [PRE_W-1:0] prescale,
  input  logic             auto_send,
  input  logic             cmd_we,
  input  logic [3:0]       cmd_code,
  input  logic             tx_valid,
  output logic             tx_ready,
  input  logic [DW-1:0]    tx_data,
  input  logic             ack_we,
  input  logic             ack_wval,
  input  logic             done_clr,
  output logic [DW-1:0]    rx_data,
  output logic             busy,
  output logic             done,
  output logic             ack_in,
  output logic             ack_out,
  output logic             engine_active,
  output logic             scl_oe,
  output logic             sda_oe,
  input  logic             sda_in
);
  logic          tx_fire, go, eng_active, op_done, tick, running;
  op_e           go_op;
  logic [DW-1:0] tx_q, eng_rx;

  assign tx_ready      = !running;
  assign tx_fire       = tx_valid && tx_ready;
  assign engine_active = running;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       tx_q <= '0;
    else if (tx_fire) tx_q <= tx_data;
  end

  i2c_cmd_seq #(.DW(DW)) u_seq (
    .clk(clk), .rst_n(rst_n), .cmd_we(cmd_we), .cmd_code(cmd_code),
    .tx_fire(tx_fire), .auto_send(auto_send), .ack_we(ack_we),
    .ack_wval(ack_wval), .done_clr(done_clr), .op_done(op_done),
    .eng_rx(eng_rx), .go(go), .go_op(go_op), .running(running),
    .busy(busy), .done(done), .ack_in(ack_in), .ack_out(ack_out),
    .rx_data(rx_data)
  );

  i2c_qtick #(.PRE_W(PRE_W)) u_tick (
    .clk(clk), .rst_n(rst_n), .run(eng_active), .prescale(prescale), .tick(tick)
  );

  i2c_bit_engine #(.DW(DW)) u_eng (
    .clk(clk), .rst_n(rst_n), .go(go), .go_op(go_op), .tx_byte(tx_q),
    .ack_bit(ack_out), .sda_in(sda_in), .tick(tick), .active(eng_active),
    .op_done(op_done), .rx_sh(eng_rx), .scl_oe(scl_oe), .sda_oe(sda_oe)
  );

endmodule

// File: tb/i2c_cmd_master_tb.sv
module i2c_cmd_master_tb;
  logic clk = 1'b0;
  always #4 clk = ~clk;

  logic       rst_n, auto_send, cmd_we, tx_valid, tx_ready, ack_we, ack_wval, done_clr;
  logic [5:0] prescale;
  logic [3:0] cmd_code;
  logic [7:0] tx_data, rx_data;
  logic       busy, done, ack_in, ack_out, engine_active, scl_oe, sda_oe, sda_in;

  i2c_cmd_master u_dut (
    .clk(clk), .rst_n(rst_n), .prescale(prescale), .auto_send(auto_send),
    .cmd_we(cmd_we), .cmd_code(cmd_code), .tx_valid(tx_valid), .tx_ready(tx_ready),
    .tx_data(tx_data), .ack_we(ack_we), .ack_wval(ack_wval), .done_clr(done_clr),
    .rx_data(rx_data), .busy(busy), .done(done), .ack_in(ack_in), .ack_out(ack_out),
    .engine_active(engine_active), .scl_oe(scl_oe), .sda_oe(sda_oe), .sda_in(sda_in)
  );

  int vecs = 0, errs = 0;

  // passive bus monitor
  logic scl_l, scl_p = 1'b1, sda_p = 1'b1;
  logic [15:0] bits = '0;
  int rises = 0, starts = 0, stops = 0, scl_falls = 0, cyc = 0, last_rise = 0, period = 0;
  int b_rise, b_start, b_stop, fall_base = 0;
  logic [8:0] slv_pat = 9'h1FF;
  logic slave_pull;

  assign scl_l  = ~scl_oe;
  assign sda_in = ~(sda_oe | slave_pull);

  // slave drives bit (8-k) of its pattern after the k-th SCL fall
  always_comb begin
    int k;
    k = scl_falls - fall_base;
    slave_pull = 1'b0;
    if (k >= 0 && k <= 8) slave_pull = !slv_pat[8-k];
  end

  always @(negedge clk) begin
    cyc++;
    if (scl_l && !scl_p) begin
      rises++;
      bits = {bits[14:0], sda_in};
      period = cyc - last_rise;
      last_rise = cyc;
    end
    if (!scl_l && scl_p) scl_falls++;
    if (scl_l && scl_p && !sda_in && sda_p) starts++;
    if (scl_l && scl_p && sda_in && !sda_p) stops++;
    scl_p = scl_l;
    sda_p = sda_in;
  end

  task automatic chk(input string tag, input int act, input int exp);
    vecs++;
    if (act != exp) begin
      errs++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic snap();
    b_rise = rises; b_start = starts; b_stop = stops; fall_base = scl_falls;
  endtask

  task automatic wait_done(input bit clr);
    int n = 0;
    while (!done && n < 50000) begin @(negedge clk); n++; end
    chk("R8 done set at completion", done, 1);
    if (clr) begin
      @(negedge clk); done_clr = 1'b1;
      @(negedge clk); done_clr = 1'b0;
    end
  endtask

  task automatic pulse_cmd(input logic [3:0] c);
    @(negedge clk); cmd_we = 1'b1; cmd_code = c;
    @(negedge clk); cmd_we = 1'b0;
  endtask

  task automatic run_cmd(input logic [3:0] c);
    pulse_cmd(c);
    wait_done(1'b1);
  endtask

  task automatic put_tx(input logic [7:0] d);
    @(negedge clk); tx_valid = 1'b1; tx_data = d;
    @(negedge clk); tx_valid = 1'b0;
  endtask

  task automatic t_reset();
    chk("R1 scl_oe", scl_oe, 0);
    chk("R1 sda_oe", sda_oe, 0);
    chk("R1 busy", busy, 0);
    chk("R1 done", done, 0);
    chk("R1 engine_active", engine_active, 0);
    chk("R1 tx_ready", tx_ready, 1);
  endtask

  task automatic t_start();
    prescale = 6'd0; slv_pat = 9'h1FF; snap();
    run_cmd(4'h1);
    chk("R2 start count", starts - b_start, 1);
    chk("R2 busy", busy, 1);
    chk("R2 scl held low", scl_oe, 1);
  endtask

  task automatic t_send();
    put_tx(8'hA5); slv_pat = 9'h1FF; snap();
    run_cmd(4'h2);
    chk("R3 pulses", rises - b_rise, 8);
    chk("R3 data msb first", bits[7:0], 8'hA5);
    chk("R3 no start/stop", (starts - b_start) + (stops - b_stop), 0);
    chk("R9 period P=0", period, 8);
  endtask

  task automatic t_rack();
    slv_pat = 9'b0_1111_1111; snap();
    run_cmd(4'h3);
    chk("R4 pulses", rises - b_rise, 1);
    chk("R4 ack low", ack_in, 0);
    slv_pat = 9'h1FF; snap();
    run_cmd(4'h3);
    chk("R4 ack high", ack_in, 1);
  endtask

  task automatic t_recv();
    prescale = 6'd5; slv_pat = {8'h3C, 1'b1}; snap();
    run_cmd(4'h4);
    chk("R5 rx byte", rx_data, 8'h3C);
    chk("R5 pulses", rises - b_rise, 8);
    chk("R9 period P=5", period, 28);
  endtask

  task automatic t_tack();
    slv_pat = 9'h1FF;
    @(negedge clk); ack_we = 1'b1; ack_wval = 1'b0;
    @(negedge clk); ack_we = 1'b0;
    snap(); run_cmd(4'h5);
    chk("R6 ack_out", ack_out, 0);
    chk("R6 sda ack", bits[0], 0);
    chk("R6 pulses", rises - b_rise, 1);
    @(negedge clk); ack_we = 1'b1; ack_wval = 1'b1;
    @(negedge clk); ack_we = 1'b0;
    snap(); run_cmd(4'h5);
    chk("R6 sda nack", bits[0], 1);
  endtask

  task automatic t_done_sticky();
    slv_pat = 9'h1FF; snap();
    pulse_cmd(4'h5);
    wait_done(1'b0);
    repeat (30) @(negedge clk);
    chk("R8 done sticky", done, 1);
    @(negedge clk); done_clr = 1'b1;
    @(negedge clk); done_clr = 1'b0;
    chk("R8 done cleared", done, 0);
  endtask

  task automatic t_compound();
    prescale = 6'd1;
    put_tx(8'h96); slv_pat = {8'hFF, 1'b0}; snap();
    run_cmd(4'hA);
    chk("R10 0xA pulses", rises - b_rise, 9);
    chk("R10 0xA bits", bits[8:0], {8'h96, 1'b0});
    chk("R10 0xA ack_in", ack_in, 0);
    slv_pat = {8'h5A, 1'b1}; snap();
    run_cmd(4'hB);
    chk("R10 0xB rx", rx_data, 8'h5A);
    chk("R10 0xB ack bit", bits[0], 0);
    chk("R10 0xB ack_out", ack_out, 0);
    slv_pat = {8'hC3, 1'b1}; snap();
    run_cmd(4'hC);
    chk("R10 0xC rx", rx_data, 8'hC3);
    chk("R10 0xC nack bit", bits[0], 1);
    chk("R10 0xC ack_out", ack_out, 1);
  endtask

  task automatic t_stop();
    slv_pat = 9'h1FF; snap();
    run_cmd(4'h6);
    chk("R7 stop count", stops - b_stop, 1);
    chk("R7 busy", busy, 0);
    chk("R7 scl released", scl_oe, 0);
    chk("R7 sda released", sda_oe, 0);
  endtask

  task automatic t_cmd9();
    put_tx(8'h4B); slv_pat = {8'hFF, 1'b0}; snap();
    fall_base = fall_base + 2;  // START from idle makes two SCL falls
    run_cmd(4'h9);
    chk("R10 0x9 start", starts - b_start, 1);
    chk("R10 0x9 bits", bits[8:0], {8'h4B, 1'b0});
    chk("R10 0x9 ack_in", ack_in, 0);
    chk("R10 0x9 busy", busy, 1);
  endtask

  task automatic t_auto();
    prescale = 6'd0; auto_send = 1'b1;
    slv_pat = {8'hFF, 1'b0}; snap();
    put_tx(8'h71);
    repeat (2) @(negedge clk);
    chk("R11 tx_ready low while running", tx_ready, 0);
    chk("R11 engine running", engine_active, 1);
    wait_done(1'b1);
    chk("R11 auto pulses", rises - b_rise, 9);
    chk("R11 auto bits", bits[8:1], 8'h71);
    chk("R11 auto ack", ack_in, 0);
    auto_send = 1'b0;
  endtask

  task automatic t_ignore();
    prescale = 6'd2;
    put_tx(8'h3E);
    slv_pat = {8'hA7, 1'b1}; snap();
    pulse_cmd(4'h4);
    repeat (10) @(negedge clk);
    pulse_cmd(4'h6);
    put_tx(8'hFF);
    wait_done(1'b1);
    chk("R12 stop ignored", stops - b_stop, 0);
    chk("R12 pulses", rises - b_rise, 8);
    chk("R12 rx", rx_data, 8'hA7);
    chk("R12 busy kept", busy, 1);
    snap();
    pulse_cmd(4'h7);
    pulse_cmd(4'h0);
    pulse_cmd(4'hE);
    repeat (40) @(negedge clk);
    chk("R12 bad code no done", done, 0);
    chk("R12 bad code idle", engine_active, 0);
    chk("R12 bad code no pulses", rises - b_rise, 0);
    slv_pat = 9'h1FF; snap();
    run_cmd(4'h2);
    chk("R11 word offered while busy not taken", bits[7:0], 8'h3E);
  endtask

  task automatic t_slow();
    prescale = 6'd63; slv_pat = 9'h1FF; put_tx(8'h81); snap();
    run_cmd(4'h2);
    chk("R9 period P=63", period, 260);
    chk("R3 slow data", bits[7:0], 8'h81);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errs++; vecs++;
    $display("FAIL watchdog expired actual=0 expected=1");
    $display("== %0d vectors applied, %0d miscompares ==", vecs, errs);
    $finish;
  end

  initial begin
    rst_n = 1'b0; prescale = '0; auto_send = 1'b0; cmd_we = 1'b0; cmd_code = '0;
    tx_valid = 1'b0; tx_data = '0; ack_we = 1'b0; ack_wval = 1'b0; done_clr = 1'b0;
    repeat (5) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    @(negedge clk);
    t_start();
    t_send();
    t_rack();
    t_recv();
    t_tack();
    t_done_sticky();
    t_compound();
    t_stop();
    t_cmd9();
    t_auto();
    t_ignore();
    t_slow();
    t_stop();
    $display("== %0d vectors applied, %0d miscompares ==", vecs, errs);
    $finish;
  end

endmodule